// File: doc/BRIEF.md
# Interrupt Controller Command Word Sequencer

This block is the register-bus front end of a priority interrupt controller. A processor reaches it through chip select, a one-bit address, a write strobe and a read strobe. The block works out what each written byte means and turns it into static configuration fields and one-cycle command pulses for the controller core. It also returns the mask, request or in-service register when the processor reads.

The same address means different things as setup progresses. A byte at address 0 with bit 4 set always starts a new setup. The next address-1 writes then fill, in a fixed order, the vector base, the cascade word and the optional-feature word. The cascade word is skipped when the start word chose single mode. The optional-feature word is skipped unless the start word asked for it. Once setup is complete, address 1 writes the mask register. Address 0 carries either an end-of-interrupt / priority command or a read-select / poll command, and bit 3 tells them apart. Every write is one clock cycle in which `cs` and `wr` are both high.

Top module: `irq_cmd_seq`

## Requirements
- R1: After reset, `init_done`, `cmd_pulse` and `poll_ack` are 0, and the mask register is 0. Reads at address 0 select the request register. All configuration outputs are 0.
- R2: A write at address 0 with data bit 4 set is a start word in any state. It captures the expect-feature-word flag (bit 0), the single-mode flag (bit 1), the processor-mode flag (bit 2) and the level-trigger flag (bit 3). It clears the mask register, the poll request and the three feature outputs. It selects the request register for reads, drops `init_done` and awaits the vector base.
- R3: After a start word, address-1 writes load the vector base (`vec_base`), then `casc_cfg` if single mode is clear, then the feature word if bit 0 of the start word was set. `init_done` rises in the cycle after the last of these words.
- R4: The feature word sets `auto_eoi` from bit 1, `buffered` from bit 3 and `special_nest` from bit 4. When no feature word is sent, all three stay 0. `slave_id` always equals bits 2:0 of `casc_cfg`.
- R5: While `init_done` is high, an address-1 write replaces the mask register. A read at address 1 returns the mask register at any time.
- R6: While `init_done` is high, an address-0 write with bits 4 and 3 clear is a priority command. In the next cycle `cmd_pulse` is high for exactly one cycle, with `cmd_code` equal to data bits 7:5 and `cmd_level` equal to data bits 2:0. Code 3'b010 is a no-operation and gives no pulse.
- R7: While `init_done` is high, an address-0 write with bit 4 clear and bit 3 set is a read-select command. If bit 1 is set, bit 0 selects the register for address-0 reads: 1 for in-service, 0 for request. If bit 1 is clear, the selection is kept.
- R8: A read at address 0 with no poll pending returns `isr_in` or `irr_in`, as the selection gives. `dout` is 0 while no read is under way.
- R9: A read-select command with bit 2 set arms a poll. The next address-0 read returns `poll_data`, with `poll_ack` high during that read. The poll is then disarmed, and later reads follow the selection again.
- R10: Before the first start word, and during setup, writes that are neither a start word nor the awaited address-1 word have no effect. They change no register and produce no command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| a0 | input | 1 | Register address bit |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| irr_in | input | 8 | Request register from the core |
| isr_in | input | 8 | In-service register from the core |
| poll_data | input | 8 | Poll result word from the core |
| init_done | output | 1 | Setup sequence complete |
| single_mode | output | 1 | Single controller, no cascade word |
| cpu_mode | output | 1 | Processor-mode flag from the start word |
| level_trig | output | 1 | Level-triggered request flag |
| vec_base | output | 8 | Vector base |
| casc_cfg | output | 8 | Cascade word: slave bitmask for a master |
| slave_id | output | 3 | Slave identity, the low bits of the cascade word |
| auto_eoi | output | 1 | Automatic end-of-interrupt enable |
| buffered | output | 1 | Buffered bus mode enable |
| special_nest | output | 1 | Special fully nested mode enable |
| mask | output | 8 | Interrupt mask register |
| cmd_pulse | output | 1 | One-cycle priority command strobe |
| cmd_code | output | 3 | Priority command type |
| cmd_level | output | 3 | Level number for the command |
| poll_ack | output | 1 | Poll word being read |

## Verification
Setup is tried along four paths: single mode with no feature word, cascade mode with the feature word, cascade mode without it, and a restart in the middle of run time. Together they show that the skip decisions read the right start-word bits. Priority commands are sent as a non-specific end, a specific end with a level, and the no-operation code, which shows that the code and level fields are passed through and that the no-operation code is filtered out. Read-select words with the select bit set and cleared tell an update apart from a kept selection. A poll followed by a plain read shows that the poll lasts for one read only. Stray writes before setup show that they are ignored.

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       a0,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  input  logic [7:0] poll_data,
  output logic       init_done,
  output logic       single_mode,
  output logic       cpu_mode,
  output logic       level_trig,
  output logic [7:0] vec_base,
  output logic [7:0] casc_cfg,
  output logic [2:0] slave_id,
  output logic       auto_eoi,
  output logic       buffered,
  output logic       special_nest,
  output logic [7:0] mask,
  output logic       cmd_pulse,
  output logic [2:0] cmd_code,
  output logic [2:0] cmd_level,
  output logic       poll_ack
);
  typedef enum logic [2:0] {ST_IDLE, ST_VEC, ST_CASC, ST_OPT, ST_RUN} seq_t;
  localparam logic [2:0] NOP_CODE = 3'b010;

  seq_t       state;
  logic       need_opt, sel_isr, poll_armed;
  logic [7:0] mask_q;
  logic       wr_en, start_hit, rd_lo;

  assign wr_en     = cs & wr;
  assign start_hit = wr_en & ~a0 & din[4];
  assign rd_lo     = cs & rd & ~a0;
  assign poll_ack  = rd_lo & poll_armed;
  assign init_done = (state == ST_RUN);
  assign slave_id  = casc_cfg[2:0];
  assign mask      = mask_q;

  always_comb begin
    dout = 8'h00;
    if (cs && rd) begin
      if (a0)              dout = mask_q;
      else if (poll_armed) dout = poll_data;
      else if (sel_isr)    dout = isr_in;
      else                 dout = irr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      need_opt     <= 1'b0;
      single_mode  <= 1'b0;
      cpu_mode     <= 1'b0;
      level_trig   <= 1'b0;
      vec_base     <= 8'h00;
      casc_cfg     <= 8'h00;
      auto_eoi     <= 1'b0;
      buffered     <= 1'b0;
      special_nest <= 1'b0;
      mask_q       <= 8'h00;
      sel_isr      <= 1'b0;
      poll_armed   <= 1'b0;
      cmd_pulse    <= 1'b0;
      cmd_code     <= 3'b000;
      cmd_level    <= 3'b000;
    end else begin
      cmd_pulse <= 1'b0;
      if (poll_ack) poll_armed <= 1'b0;
      if (start_hit) begin
        state        <= ST_VEC;
        need_opt     <= din[0];
        single_mode  <= din[1];
        cpu_mode     <= din[2];
        level_trig   <= din[3];
        mask_q       <= 8'h00;
        sel_isr      <= 1'b0;
        poll_armed   <= 1'b0;
        auto_eoi     <= 1'b0;
        buffered     <= 1'b0;
        special_nest <= 1'b0;
      end else if (wr_en) begin
        case (state)
          ST_VEC: if (a0) begin
            vec_base <= din;
            if (!single_mode)  state <= ST_CASC;
            else if (need_opt) state <= ST_OPT;
            else               state <= ST_RUN;
          end
          ST_CASC: if (a0) begin
            casc_cfg <= din;
            state    <= need_opt ? ST_OPT : ST_RUN;
          end
          ST_OPT: if (a0) begin
            auto_eoi     <= din[1];
            buffered     <= din[3];
            special_nest <= din[4];
            state        <= ST_RUN;
          end
          ST_RUN: begin
            if (a0) mask_q <= din;
            else if (!din[3]) begin
              if (din[7:5] != NOP_CODE) begin
                cmd_pulse <= 1'b1;
                cmd_code  <= din[7:5];
                cmd_level <= din[2:0];
              end
            end else begin
              if (din[1]) sel_isr <= din[0];
              if (din[2]) poll_armed <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       a0,
  input logic       wr,
  input logic [7:0] din,
  input logic       init_done,
  input logic [7:0] mask,
  input logic       cmd_pulse,
  input logic [2:0] cmd_code,
  input logic       poll_ack,
  input logic       poll_armed
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !a0 && din[4]) |=> (mask == 8'h00 && !init_done && !poll_armed));

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_done) |-> $past(cs && wr && !a0 && din[4]));

  // R6
  nop_filtered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> (cmd_code != 3'b010));

  // R10
  pulse_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse |-> init_done);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse && !(cs && wr)) |=> !cmd_pulse);

  // R9
  poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_ack && !(cs && wr)) |=> !poll_armed);
endmodule

bind irq_cmd_seq irq_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr), .din(din),
  .init_done(init_done), .mask(mask), .cmd_pulse(cmd_pulse),
  .cmd_code(cmd_code), .poll_ack(poll_ack), .poll_armed(poll_armed)
);

// File: tb/irq_cmd_seq_bench.sv
module irq_cmd_seq_bench;
  logic clk = 0, rst_n = 0, cs = 0, a0 = 0, wr = 0, rd = 0;
  logic [7:0] din = 0, irr_in = 8'h3C, isr_in = 8'h81, poll_data = 8'h86;
  logic [7:0] dout, vec_base, casc_cfg, mask;
  logic [2:0] slave_id, cmd_code, cmd_level;
  logic init_done, single_mode, cpu_mode, level_trig, auto_eoi, buffered;
  logic special_nest, cmd_pulse, poll_ack;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_cmd_seq u_irq_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr), .rd(rd), .din(din),
    .dout(dout), .irr_in(irr_in), .isr_in(isr_in), .poll_data(poll_data),
    .init_done(init_done), .single_mode(single_mode), .cpu_mode(cpu_mode),
    .level_trig(level_trig), .vec_base(vec_base), .casc_cfg(casc_cfg),
    .slave_id(slave_id), .auto_eoi(auto_eoi), .buffered(buffered),
    .special_nest(special_nest), .mask(mask), .cmd_pulse(cmd_pulse),
    .cmd_code(cmd_code), .cmd_level(cmd_level), .poll_ack(poll_ack));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic addr, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; a0 = addr; din = d;
    @(negedge clk); cs = 0; wr = 0; a0 = 0; din = 0;
  endtask

  task automatic bus_rd(input logic addr, output logic [7:0] d, output logic ack);
    @(negedge clk); cs = 1; rd = 1; a0 = addr;
    #1 d = dout; ack = poll_ack;
    @(negedge clk); cs = 0; rd = 0; a0 = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic k;
    check("R1 init_done", init_done, 0);
    check("R1 cmd_pulse", cmd_pulse, 0);
    check("R1 vec_base", vec_base, 0);
    check("R1 auto_eoi", auto_eoi, 0);
    check("R1 dout idle", dout, 0);
    bus_rd(1, d, k); check("R1 mask read", d, 8'h00);
    bus_rd(0, d, k); check("R1 default select irr", d, irr_in);
  endtask

  task automatic t_stray();
    logic [7:0] d; logic k;
    bus_wr(1, 8'hFF);
    bus_wr(0, 8'h20); check("R10 no pulse before setup", cmd_pulse, 0);
    bus_rd(1, d, k); check("R10 mask untouched", d, 8'h00);
    check("R10 vec untouched", vec_base, 0);
  endtask

  task automatic t_single();
    bus_wr(0, 8'h1E);
    check("R2 single flag", single_mode, 1);
    check("R2 cpu_mode", cpu_mode, 1);
    check("R2 level_trig", level_trig, 1);
    check("R3 not done after start", init_done, 0);
    bus_wr(0, 8'h20); check("R10 no pulse mid setup", cmd_pulse, 0);
    bus_wr(1, 8'h20);
    check("R3 vec_base", vec_base, 8'h20);
    check("R3 done after vector", init_done, 1);
    check("R4 feature off when skipped", {auto_eoi, buffered, special_nest}, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d; logic k;
    bus_wr(1, 8'hA5);
    bus_rd(1, d, k); check("R5 mask readback", d, 8'hA5);
    check("R5 mask port", mask, 8'hA5);
  endtask

  task automatic t_select();
    logic [7:0] d; logic k;
    bus_rd(0, d, k); check("R8 request reg", d, irr_in);
    bus_wr(0, 8'h0B);
    bus_rd(0, d, k); check("R7 in-service selected", d, isr_in);
    bus_wr(0, 8'h08);
    bus_rd(0, d, k); check("R7 selection kept", d, isr_in);
    bus_wr(0, 8'h0A);
    bus_rd(0, d, k); check("R7 request reselected", d, irr_in);
  endtask

  task automatic t_cmds();
    @(negedge clk); cs = 1; wr = 1; a0 = 0; din = 8'h20;
    @(negedge clk); cs = 0; wr = 0; din = 0;
    check("R6 pulse", cmd_pulse, 1);
    check("R6 code nonspecific", cmd_code, 3'b001);
    @(negedge clk); check("R6 one cycle", cmd_pulse, 0);
    bus_wr(0, 8'h63);
    check("R6 pulse specific", cmd_pulse, 1);
    check("R6 code specific", cmd_code, 3'b011);
    check("R6 level", cmd_level, 3);
    bus_wr(0, 8'hA5);
    check("R6 rotate code", cmd_code, 3'b101);
    check("R6 rotate level", cmd_level, 5);
    bus_wr(0, 8'h47); check("R6 nop no pulse", cmd_pulse, 0);
  endtask

  task automatic t_poll();
    logic [7:0] d; logic k;
    bus_wr(0, 8'h0C);
    bus_rd(0, d, k);
    check("R9 poll data", d, poll_data);
    check("R9 poll_ack", k, 1);
    bus_rd(0, d, k);
    check("R9 poll disarmed", d, irr_in);
    check("R9 ack low", k, 0);
  endtask

  task automatic t_cascade_opt();
    logic [7:0] d; logic k;
    bus_wr(0, 8'h0B);
    bus_wr(0, 8'h11);
    check("R2 restart drops done", init_done, 0);
    check("R2 mask cleared", mask, 0);
    bus_wr(1, 8'h40);
    check("R3 wait cascade", init_done, 0);
    bus_wr(1, 8'h04);
    check("R3 casc_cfg", casc_cfg, 8'h04);
    check("R4 slave_id", slave_id, 3'd4);
    check("R3 wait feature", init_done, 0);
    bus_wr(1, 8'h12);
    check("R3 done after feature", init_done, 1);
    check("R4 auto_eoi", auto_eoi, 1);
    check("R4 special_nest", special_nest, 1);
    check("R4 buffered", buffered, 0);
    check("R3 vec", vec_base, 8'h40);
    bus_rd(0, d, k); check("R2 select reset to request", d, irr_in);
  endtask

  task automatic t_cascade_noopt();
    bus_wr(0, 8'h10);
    check("R2 feature cleared", auto_eoi, 0);
    bus_wr(1, 8'h70);
    bus_wr(1, 8'h83);
    check("R3 done after cascade", init_done, 1);
    check("R4 slave_id low bits", slave_id, 3'd3);
    check("R4 buffered skipped", buffered, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stray();
    t_single();
    t_mask();
    t_select();
    t_cmds();
    t_poll();
    t_cascade_opt();
    t_cascade_noopt();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule